// File: doc/BRIEF.md
# Farrow Cubic Rate Converter (320 → 441)

This block resamples a stream of signed 12-bit samples (11 fractional bits) by the exact ratio 441 outputs for every 320 inputs. That ratio is the step from 32 kHz to 44.1 kHz. Each output is a cubic Lagrange interpolation over the four newest input samples. It is computed in Farrow form: four branch filters turn the sample window into polynomial coefficients, and a Horner evaluator applies the fractional delay to them. The fractional delay comes from an integer phase accumulator that counts modulo 441, so the output rate has no drift. No bank of stored polyphase coefficients is used.

The block runs on one fast clock, nominally 14.112 MHz (441 × 32 kHz). The output rate is set by the output clock enable `out_en`. Each cycle in which `out_en` is high requests one output. Input samples are pulled through a valid/ready handshake only when the phase wraps. If a sample is needed and `in_valid` is low, the request is skipped and the phase does not move. After reset the block first takes four samples, with no outputs, to fill its window.

Top module: `farrow_src`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1, with the window cleared and the phase at 0.
- R2: Until four samples have been accepted, `in_ready` stays 1 whatever `out_en` is, and no output is produced.
- R3: The phase value p lies in 0..440. Each output step changes p to p+320 if that is below 441, otherwise to p+320−441, and a step that wraps consumes exactly one new sample. Starting from phase 0, the first 441 outputs consume exactly 320 samples after the 4 fill samples.
- R4: Once filled, `in_ready` is 1 exactly when `out_en` is 1 and p+320 ≥ 441. A step happens when `out_en` is 1 and either no wrap is due or `in_valid` is 1. A sample is taken only when `in_valid` and `in_ready` are both 1; otherwise it is ignored.
- R5: The first output after the fill uses phase 0, so it equals the second sample accepted, bit for bit.
- R6: Each output equals, within 2 LSB, the cubic Lagrange polynomial through the window (oldest to newest at positions −1, 0, 1, 2), evaluated at mu = p/441 using the phase p before the step, rounded to nearest. The window used is the one before any sample consumed by that same step.
- R7: Results beyond the 12-bit range are clamped to 2047 or −2048 and never wrap.
- R8: If a step happens in the cycle ending at clock edge k, `out_valid` is 1 for the one cycle after edge k+1. At all other times `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (nominally 441 × input rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes the offered sample this cycle |
| in_data | input | 12 | Signed input sample, 11 fractional bits |
| out_en | input | 1 | Output clock enable: request one output |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 12 | Signed output sample, 11 fractional bits |

## Verification
One output step can do two things in the same cycle: consume a new sample into the window, and evaluate an output from the window as it stood before that sample arrived. A shift that is one cycle early or late shows up as a wrong value. The bench provokes this by running with `out_en` held high so steps come back to back, and by mixing in random gaps in `in_valid`, so that wrap steps sometimes stall and sometimes go through. Its behavioural model keeps its own window and phase and predicts `in_ready` on every cycle, the cycle of every output strobe, and each value within 2 LSB. The value must be exact for the first output and for strongly clamped results.

// File: rtl/farrow_src_pkg.sv
// Shared constants and types for the Farrow cubic rate converter.
// Assumes a cubic (four-point) interpolator; changing TAPS alone does not
// change the polynomial order.
package farrow_src_pkg;
    localparam int TAPS      = 4;  // points in the cubic window
    localparam int LAG_SCALE = 6;  // common denominator of cubic Lagrange weights

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } src_mode_t;
endpackage

// File: rtl/farrow_src_phase.sv
// Phase tracker: exact modulo-DEN accumulator advanced by NUM per output,
// fill control for the first TAPS samples, handshake and step decision, and
// fractional delay mu = acc/DEN computed with a reciprocal multiply.
// Assumes NUM < DEN (at most one sample consumed per output).
module farrow_src_phase
    import farrow_src_pkg::*;
#(
    parameter int NUM = 320,
    parameter int DEN = 441,
    parameter int MUW = 16,
    parameter int RSH = 10,
    localparam int ACW = $clog2(DEN + NUM)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           out_en,
    output logic           in_ready,
    output logic           step,
    output logic           load,
    output logic           fill_done,
    output logic [ACW-1:0] acc_o,
    output logic [MUW-1:0] mu_o
);
    localparam int FCW = $clog2(TAPS + 1);
    localparam logic [63:0] RECIP =
        ((64'd1 << (MUW + RSH)) + 64'(DEN / 2)) / 64'(DEN);

    src_mode_t      mode_q;
    logic [FCW-1:0] cnt_q;
    logic [ACW-1:0] acc_q;
    logic [ACW-1:0] sum;
    logic           need;

    // Handshake and step decision from the current phase.
    always_comb begin
        sum       = acc_q + ACW'(NUM);
        need      = (sum >= ACW'(DEN));
        fill_done = (mode_q == PH_RUN);
        in_ready  = !fill_done || (out_en && need);
        step      = fill_done && out_en && (!need || in_valid);
        load      = in_valid && in_ready;
    end

    // Fill counting and exact phase advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PH_FILL;
            cnt_q  <= '0;
            acc_q  <= '0;
        end else begin
            if (!fill_done && load) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == FCW'(TAPS - 1)) mode_q <= PH_RUN;
            end
            if (step) acc_q <= need ? ACW'(sum - ACW'(DEN)) : sum;
        end
    end

    // Fractional delay as an unsigned MUW-bit fraction.
    assign mu_o  = MUW'((64'(acc_q) * RECIP) >> RSH);
    assign acc_o = acc_q;
endmodule

// File: rtl/farrow_src_taps.sv
// Delay line of TAPS samples and the four Lagrange branch filters, scaled
// by LAG_SCALE so all weights are integers. Coefficients and mu are
// registered on each output step (pipeline stage 1).
module farrow_src_taps
    import farrow_src_pkg::*;
#(
    parameter int DW  = 12,
    parameter int MUW = 16,
    parameter int CW  = DW + 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic signed [DW-1:0] din,
    input  logic [MUW-1:0]       mu,
    output logic                 c_vld,
    output logic signed [CW-1:0] c0,
    output logic signed [CW-1:0] c1,
    output logic signed [CW-1:0] c2,
    output logic signed [CW-1:0] c3,
    output logic [MUW-1:0]       mu_q
);
    logic signed [DW-1:0] win [TAPS];
    logic signed [CW-1:0] e0, e1, e2, e3;
    logic signed [CW-1:0] k0, k1, k2, k3;

    // Shift register: index TAPS-1 holds the newest sample.
    for (genvar i = 0; i < TAPS; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) win[i] <= '0;
            else if (load) begin
                if (i == TAPS - 1) win[i] <= din;
                else               win[i] <= win[i+1];
            end
        end
    end

    // Branch filters: six times the cubic Lagrange Farrow coefficients.
    always_comb begin
        e0 = CW'(win[0]);
        e1 = CW'(win[1]);
        e2 = CW'(win[2]);
        e3 = CW'(win[3]);
        k0 = (e1 <<< 2) + (e1 <<< 1);
        k1 = (e2 <<< 2) + (e2 <<< 1) - (e0 <<< 1) - (e1 <<< 1) - e1 - e3;
        k2 = (e0 <<< 1) + e0 + (e2 <<< 1) + e2 - (e1 <<< 2) - (e1 <<< 1);
        k3 = (e1 <<< 1) + e1 + e3 - e0 - (e2 <<< 1) - e2;
    end

    // Stage-1 register: capture coefficients and mu on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_vld <= 1'b0;
            c0    <= '0;
            c1    <= '0;
            c2    <= '0;
            c3    <= '0;
            mu_q  <= '0;
        end else begin
            c_vld <= step;
            if (step) begin
                c0   <= k0;
                c1   <= k1;
                c2   <= k2;
                c3   <= k3;
                mu_q <= mu;
            end
        end
    end
endmodule

// File: rtl/farrow_src_horner.sv
// Horner evaluation ((c3*mu + c2)*mu + c1)*mu + c0 with GF guard bits,
// removal of the LAG_SCALE factor by a reciprocal multiply, round to
// nearest and clamp to DW bits. Output registered (pipeline stage 2).
module farrow_src_horner
    import farrow_src_pkg::*;
#(
    parameter int DW  = 12,
    parameter int MUW = 16,
    parameter int CW  = DW + 4,
    parameter int GF  = 4,
    parameter int RS  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 c_vld,
    input  logic signed [CW-1:0] c0,
    input  logic signed [CW-1:0] c1,
    input  logic signed [CW-1:0] c2,
    input  logic signed [CW-1:0] c3,
    input  logic [MUW-1:0]       mu,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int HW = CW + 2 + GF;
    localparam int PW = HW + MUW + 1;
    localparam int QW = HW + RS + 2;
    localparam int SH = GF + RS;
    localparam logic signed [RS:0]   RCP  = (RS + 1)'(((2 ** RS) + LAG_SCALE / 2) / LAG_SCALE);
    localparam logic signed [QW-1:0] RND  = QW'(1) <<< (SH - 1);
    localparam logic signed [QW-1:0] YMAX = QW'((2 ** (DW - 1)) - 1);
    localparam logic signed [QW-1:0] YMIN = QW'(-(2 ** (DW - 1)));

    logic signed [MUW:0]  mu_s;
    logic signed [HW-1:0] h3, h2, h1, h0;
    logic signed [PW-1:0] p3, p2, p1;
    logic signed [QW-1:0] q, qr, ysat;

    // Horner chain, scale removal, rounding and clamping.
    always_comb begin
        mu_s = $signed({1'b0, mu});
        h3   = HW'(c3) <<< GF;
        p3   = h3 * mu_s;
        h2   = HW'(p3 >>> MUW) + (HW'(c2) <<< GF);
        p2   = h2 * mu_s;
        h1   = HW'(p2 >>> MUW) + (HW'(c1) <<< GF);
        p1   = h1 * mu_s;
        h0   = HW'(p1 >>> MUW) + (HW'(c0) <<< GF);
        q    = QW'(h0) * QW'(RCP);
        qr   = (q + RND) >>> SH;
        if (qr > YMAX)      ysat = YMAX;
        else if (qr < YMIN) ysat = YMIN;
        else                ysat = qr;
    end

    // Stage-2 register: output sample and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= c_vld;
            if (c_vld) out_data <= DW'(ysat);
        end
    end
endmodule

// File: rtl/farrow_src.sv
// Top of the Farrow cubic Lagrange rate converter (NUM inputs per DEN
// outputs). out_en paces the outputs; inputs are pulled with valid/ready
// only when the phase wraps. Latency: two clocks from step to out_valid.
module farrow_src #(
    parameter int DW  = 12,
    parameter int NUM = 320,
    parameter int DEN = 441,
    parameter int MUW = 16,
    parameter int RSH = 10,
    parameter int GF  = 4,
    parameter int RS  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_data,
    input  logic                 out_en,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int CW  = DW + 4;
    localparam int ACW = $clog2(DEN + NUM);

    logic           step, load, fill_done, c_vld;
    logic [ACW-1:0] acc_cur;
    logic [MUW-1:0] mu_cur, mu_q;
    logic signed [CW-1:0] c0, c1, c2, c3;

    farrow_src_phase #(.NUM(NUM), .DEN(DEN), .MUW(MUW), .RSH(RSH)) phase_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_en(out_en),
        .in_ready(in_ready), .step(step), .load(load), .fill_done(fill_done),
        .acc_o(acc_cur), .mu_o(mu_cur)
    );

    farrow_src_taps #(.DW(DW), .MUW(MUW), .CW(CW)) taps_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .din(in_data),
        .mu(mu_cur), .c_vld(c_vld), .c0(c0), .c1(c1), .c2(c2), .c3(c3),
        .mu_q(mu_q)
    );

    farrow_src_horner #(.DW(DW), .MUW(MUW), .CW(CW), .GF(GF), .RS(RS)) horner_i (
        .clk(clk), .rst_n(rst_n), .c_vld(c_vld), .c0(c0), .c1(c1), .c2(c2),
        .c3(c3), .mu(mu_q), .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/farrow_src_chk.sv
// Protocol and phase checker for farrow_src, attached with bind.
// Assumes the phase register, step and fill flag of the top are visible.
module farrow_src_chk #(
    parameter int NUM = 320,
    parameter int DEN = 441,
    parameter int ACW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_en,
    input logic           out_valid,
    input logic           step,
    input logic           fill_done,
    input logic [ACW-1:0] acc
);
    assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc) < DEN);

    assert_acc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (int'(acc) == ((int'($past(acc)) + NUM >= DEN) ?
                  int'($past(acc)) + NUM - DEN : int'($past(acc)) + NUM)));

    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(acc));

    assert_fill_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_done |-> in_ready && !step);

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && in_ready && !in_valid) |-> !step);

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !step);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ##1 out_valid);

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(step, 2));
endmodule

bind farrow_src farrow_src_chk #(.NUM(NUM), .DEN(DEN), .ACW(ACW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_en(out_en), .out_valid(out_valid), .step(step),
    .fill_done(fill_done), .acc(acc_cur)
);

// File: tb/farrow_src_tb_top.sv
// Self-checking bench: a behavioural model (window, phase, queues of
// expected outputs) predicts in_ready, out_valid and out_data every cycle.
module farrow_src_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_en = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic signed [DW-1:0] out_data;

    farrow_src dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_en(out_en), .out_valid(out_valid),
        .out_data(out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_errors = 0, cyc = 0;
    int mfill, macc, src_idx, sat_seen, hs_cnt, out_cnt;
    int win[4];
    int qdue[$], qval[$], qraw[$], qfirst[$];
    int hs_at[int];
    bit first_pending;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int samp(input int mode, input int idx);
        real ph;
        case (mode)
            0: begin
                ph = 6.2831853 * (0.003 * idx + 0.00002 * idx * idx);
                return int'($floor(1900.0 * $sin(ph) + 0.5));
            end
            1: case (idx % 4)
                0: return -2048;
                1: return 2047;
                2: return 2047;
                default: return -2048;
            endcase
            default: case (idx % 8)
                0: return 100;
                1: return 500;
                2: return -300;
                3: return 700;
                4: return -1200;
                5: return 40;
                6: return 2000;
                default: return -1999;
            endcase
        endcase
    endfunction

    // Ideal cubic Lagrange through points -1,0,1,2, rounded, not clamped.
    function automatic int ideal(input int a);
        real t, y;
        t = a / 441.0;
        y = -win[0] * t * (t - 1.0) * (t - 2.0) / 6.0
            + win[1] * (t + 1.0) * (t - 1.0) * (t - 2.0) / 2.0
            - win[2] * (t + 1.0) * t * (t - 2.0) / 2.0
            + win[3] * (t + 1.0) * t * (t - 1.0) / 6.0;
        return int'($floor(y + 0.5));
    endfunction

    task automatic model_clear();
        mfill = 0; macc = 0; src_idx = 0; first_pending = 1'b1;
        for (int i = 0; i < 4; i++) win[i] = 0;
        qdue.delete(); qval.delete(); qraw.delete(); qfirst.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_en = 1'b0;
        repeat (3) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic cycle(input int mode, input int pv, input int po);
        bit exp_v, v, oe, need, er, st;
        int d, ev, raw, fst, dif;
        @(negedge clk);
        cyc++;
        // Outputs produced by the edge just passed.
        exp_v = (qdue.size() > 0) && (qdue[0] == cyc);
        chk(out_valid == exp_v, "R8 out_valid timing", int'(out_valid), int'(exp_v));
        if (out_valid) out_cnt++;
        if (exp_v) begin
            void'(qdue.pop_front());
            ev = qval.pop_front(); raw = qraw.pop_front(); fst = qfirst.pop_front();
            dif = int'(out_data) - ev;
            if (fst != 0)
                chk(dif == 0, "R5 first output", int'(out_data), ev);
            else if (raw > 2050 || raw < -2051) begin
                sat_seen++;
                chk(dif == 0, "R7 clamped output", int'(out_data), ev);
            end else
                chk(dif <= 2 && dif >= -2, "R6 interpolated value", int'(out_data), ev);
        end
        // Drive new inputs.
        v  = (int'($urandom_range(99)) < pv);
        oe = (int'($urandom_range(99)) < po);
        d  = samp(mode, src_idx);
        in_valid = v; out_en = oe; in_data = DW'(d);
        #1;
        need = (macc + 320 >= 441);
        er   = (mfill < 4) || (oe && need);
        if (mfill < 4) chk(in_ready == er, "R2 ready during fill", int'(in_ready), int'(er));
        else           chk(in_ready == er, "R4 ready in run", int'(in_ready), int'(er));
        if (v && in_ready) hs_cnt++;
        hs_at[cyc] = hs_cnt;
        st = (mfill == 4) && oe && (!need || v);
        if (st) begin
            raw = ideal(macc);
            ev  = (raw > 2047) ? 2047 : ((raw < -2048) ? -2048 : raw);
            qdue.push_back(cyc + 2); qval.push_back(ev); qraw.push_back(raw);
            qfirst.push_back(int'(first_pending));
            first_pending = 1'b0;
            macc = need ? macc + 320 - 441 : macc + 320;
        end
        if (v && er) begin
            for (int i = 0; i < 3; i++) win[i] = win[i+1];
            win[3] = d;
            src_idx++;
            if (mfill < 4) mfill++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();                                   // R1
        // Fill with out_en low, then run on a short list (R2, R5, R6).
        repeat (6)   cycle(2, 100, 0);
        repeat (40)  cycle(2, 100, 100);
        // Chirp with gaps on both sides (R4, R6, R8).
        repeat (1500) cycle(0, 70, 80);
        // Starved input: wrap steps must stall (R4).
        repeat (30)  cycle(0, 0, 100);
        repeat (200) cycle(0, 100, 30);
        // Full-scale pattern that overshoots the rails (R7).
        do_reset();
        sat_seen = 0;
        repeat (400) cycle(1, 100, 100);
        chk(sat_seen > 0, "R7 clamping provoked", sat_seen, 1);
        // Exact ratio: 441 outputs consume 320 samples after the fill (R3).
        do_reset();
        hs_cnt = 0; out_cnt = 0;
        for (int n = 0; n < 2000; n++) begin
            cycle(0, 100, 100);
            if (out_cnt == 441) break;
        end
        chk(out_cnt == 441, "R3 output count reached", out_cnt, 441);
        chk(hs_at.exists(cyc - 2) && hs_at[cyc-2] == 324, "R3 samples per 441 outputs",
            hs_at.exists(cyc - 2) ? hs_at[cyc-2] : -1, 324);
        repeat (4) cycle(0, 0, 0);
        finish_run();
    end
endmodule